// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block lands received frames in memory under control of a ring of descriptors that software sets up. Frames arrive one byte per beat on a valid/ready stream, with a marker on the final byte and an error flag that travels with that byte. For each frame the block fetches the descriptor at the produce position. A descriptor is a buffer pointer followed by a control word. The block then writes the frame bytes into that buffer and writes an 8-byte status record into a second, parallel array. Only after the status record is written does the produce index move on.

Software programs the descriptor array base, the status array base and the ring size, which is held as the slot count minus one. It hands slots back by writing the consume index. The block reports whether the ring holds nothing for software (empty) and whether it has no free slot (full). A frame that arrives while the ring is full is swallowed and counted. All memory traffic goes through one single-cycle port, and read data returns one cycle after the request.

Top module: `rx_desc_ring_writer`

## Requirements
- R1: After reset the produce index and the overrun count are 0, `ring_empty` is 1, `ring_full` is 0 and `in_ready` is 0.
- R2: While `rx_en` is 0 and no frame is in progress, no byte is accepted (`in_ready` stays 0) and the produce index does not move.
- R3: For a new frame the block reads the pointer word at `desc_base + 8*prod` and the control word at `desc_base + 8*prod + 4`. It stores frame byte i at byte address pointer+i, using a word-aligned write with exactly one byte enable set. The pointer need not be aligned.
- R4: The buffer size is control bits [10:0] plus one. All other control bits, including bit 31, have no effect.
- R5: The first status word at `stat_base + 8*prod` carries the number of stored bytes minus one in bits [10:0]. The second status word, at +4, is written as zero.
- R6: When `in_err` is set on the final byte, bit 28 of the first status word is set; otherwise it is clear.
- R7: Bytes beyond the buffer size are dropped without any memory write. Bit 23 of the first status word is then set, and the length field reads size minus one.
- R8: `ring_empty` is 1 when produce equals consume. `ring_full` is 1 when the successor of produce equals consume, where the successor of `desc_last` is 0.
- R9: A frame that starts while the ring is full is accepted and discarded, with no memory write. The overrun count rises by one and the produce index stays put.
- R10: The produce index steps by one right after the second status word is written and wraps from `desc_last` to 0. Writing the consume index frees slots for further frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| desc_base | input | 32 | Byte address of descriptor array |
| stat_base | input | 32 | Byte address of status array |
| desc_last | input | IDXW | Number of slots minus one |
| cons_wr | input | 1 | Load consume index |
| cons_wdata | input | IDXW | New consume index |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Final byte of frame |
| in_err | input | 1 | Frame error, sampled with final byte |
| in_ready | output | 1 | Stream byte taken this cycle when valid |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (else read) |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after request |
| prod_idx | output | IDXW | Produce index |
| ring_empty | output | 1 | No completed frame pending for software |
| ring_full | output | 1 | No free slot |
| ovr_cnt | output | OVRW | Dropped-frame count |

## Verification
On every cycle the assertions check four things. The produce index only ever steps to its wrapped successor, and it holds while the ring is full. The overrun count only increments. Every memory write carries either a single byte enable or a full-word enable. What lands in memory can only be shown by the bench's scenarios: which bytes reach which addresses, where truncation stops, how the status fields are encoded, and that a dropped frame leaves its buffer untouched. Those scenarios read back the memory model after each frame has been committed.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RDP, S_RDC, S_CAP, S_DATA, S_ST0, S_ST1, S_DROP
  } rxr_state_e;

  localparam int SIZE_W      = 11;  // size / length field width
  localparam int CNT_W       = SIZE_W + 1;
  localparam int TRUNC_BIT   = 23;  // buffer too small
  localparam int FERR_BIT    = 28;  // stream error on final byte
  localparam int SLOT_BYTES  = 8;
endpackage

// File: rtl/rxr_ring.sv
module rxr_ring #(
  parameter int IDXW = 8,
  parameter int OVRW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] desc_last,
  input  logic            cons_wr,
  input  logic [IDXW-1:0] cons_wdata,
  input  logic            adv,
  input  logic            drop,
  output logic [IDXW-1:0] prod,
  output logic            full,
  output logic            empty,
  output logic [OVRW-1:0] ovr
);
  logic [IDXW-1:0] cons_q, prod_n, cons_n, prod_succ;
  logic [OVRW-1:0] ovr_n;

  assign prod_succ = (prod == desc_last) ? '0 : prod + 1'b1;
  assign empty     = (prod == cons_q);
  assign full      = (prod_succ == cons_q);

  always_comb begin
    prod_n = prod;
    cons_n = cons_q;
    ovr_n  = ovr;
    if (adv)     prod_n = prod_succ;
    if (cons_wr) cons_n = cons_wdata;
    if (drop)    ovr_n  = ovr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod   <= '0;
      cons_q <= '0;
      ovr    <= '0;
    end else begin
      prod   <= prod_n;
      cons_q <= cons_n;
      ovr    <= ovr_n;
    end
  end
endmodule

// File: rtl/rxr_fsm.sv
module rxr_fsm
  import rxr_pkg::*;
#(
  parameter int IDXW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_en,
  input  logic [31:0]     desc_base,
  input  logic [31:0]     stat_base,
  input  logic [IDXW-1:0] prod,
  input  logic            full,
  input  logic            in_valid,
  input  logic [7:0]      in_data,
  input  logic            in_last,
  input  logic            in_err,
  output logic            in_ready,
  output logic            mem_en,
  output logic            mem_we,
  output logic [31:0]     mem_addr,
  output logic [3:0]      mem_be,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     mem_rdata,
  output logic            adv,
  output logic            drop
);
  rxr_state_e        st, st_n;
  logic [31:0]       ptr_q, ptr_n;
  logic [SIZE_W-1:0] szm1_q, szm1_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n, len_m1;
  logic              trunc_q, trunc_n, ferr_q, ferr_n;
  logic [31:0]       slot_off, dslot, sslot, baddr;

  assign slot_off = 32'(prod) * SLOT_BYTES;
  assign dslot    = desc_base + slot_off;
  assign sslot    = stat_base + slot_off;
  assign baddr    = ptr_q + 32'(cnt_q);
  assign len_m1   = cnt_q - 1'b1;

  always_comb begin
    st_n      = st;
    ptr_n     = ptr_q;
    szm1_n    = szm1_q;
    cnt_n     = cnt_q;
    trunc_n   = trunc_q;
    ferr_n    = ferr_q;
    in_ready  = 1'b0;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_be    = '0;
    mem_wdata = '0;
    adv       = 1'b0;
    drop      = 1'b0;
    unique case (st)
      S_IDLE: if (rx_en && in_valid) begin
        if (full) begin
          st_n = S_DROP;
          drop = 1'b1;
        end else begin
          st_n = S_RDP;
        end
      end
      S_RDP: begin
        mem_en   = 1'b1;
        mem_addr = dslot;
        cnt_n    = '0;
        trunc_n  = 1'b0;
        ferr_n   = 1'b0;
        st_n     = S_RDC;
      end
      S_RDC: begin
        mem_en   = 1'b1;
        mem_addr = dslot + 32'd4;
        ptr_n    = mem_rdata;
        st_n     = S_CAP;
      end
      S_CAP: begin
        szm1_n = mem_rdata[SIZE_W-1:0];
        st_n   = S_DATA;
      end
      S_DATA: begin
        in_ready = 1'b1;
        if (in_valid) begin
          if (cnt_q <= {1'b0, szm1_q}) begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = {baddr[31:2], 2'b00};
            mem_be    = 4'b0001 << baddr[1:0];
            mem_wdata = {4{in_data}};
            cnt_n     = cnt_q + 1'b1;
          end else begin
            trunc_n = 1'b1;
          end
          if (in_last) begin
            ferr_n = in_err;
            st_n   = S_ST0;
          end
        end
      end
      S_ST0: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sslot;
        mem_be    = 4'hF;
        mem_wdata = {3'b000, ferr_q, 4'b0000, trunc_q, 11'b0, len_m1};
        st_n      = S_ST1;
      end
      S_ST1: begin
        mem_en   = 1'b1;
        mem_we   = 1'b1;
        mem_addr = sslot + 32'd4;
        mem_be   = 4'hF;
        adv      = 1'b1;
        st_n     = S_IDLE;
      end
      S_DROP: begin
        in_ready = 1'b1;
        if (in_valid && in_last) st_n = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ptr_q   <= '0;
      szm1_q  <= '0;
      cnt_q   <= '0;
      trunc_q <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      st      <= st_n;
      ptr_q   <= ptr_n;
      szm1_q  <= szm1_n;
      cnt_q   <= cnt_n;
      trunc_q <= trunc_n;
      ferr_q  <= ferr_n;
    end
  end
endmodule

// File: rtl/rx_desc_ring_writer.sv
module rx_desc_ring_writer #(
  parameter int IDXW = 8,
  parameter int OVRW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_en,
  input  logic [31:0]     desc_base,
  input  logic [31:0]     stat_base,
  input  logic [IDXW-1:0] desc_last,
  input  logic            cons_wr,
  input  logic [IDXW-1:0] cons_wdata,
  input  logic            in_valid,
  input  logic [7:0]      in_data,
  input  logic            in_last,
  input  logic            in_err,
  output logic            in_ready,
  output logic            mem_en,
  output logic            mem_we,
  output logic [31:0]     mem_addr,
  output logic [3:0]      mem_be,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     mem_rdata,
  output logic [IDXW-1:0] prod_idx,
  output logic            ring_empty,
  output logic            ring_full,
  output logic [OVRW-1:0] ovr_cnt
);
  logic [1:0] rst_sync;
  logic       rst_q;
  logic       adv, drop;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  rxr_ring #(.IDXW(IDXW), .OVRW(OVRW)) u_ring (
    .clk(clk), .rst_n(rst_q), .desc_last(desc_last),
    .cons_wr(cons_wr), .cons_wdata(cons_wdata),
    .adv(adv), .drop(drop), .prod(prod_idx),
    .full(ring_full), .empty(ring_empty), .ovr(ovr_cnt)
  );

  rxr_fsm #(.IDXW(IDXW)) u_fsm (
    .clk(clk), .rst_n(rst_q), .rx_en(rx_en),
    .desc_base(desc_base), .stat_base(stat_base),
    .prod(prod_idx), .full(ring_full),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_err(in_err),
    .in_ready(in_ready), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .adv(adv), .drop(drop)
  );
endmodule

// File: rtl/rxr_checker.sv
module rxr_checker #(
  parameter int IDXW = 8,
  parameter int OVRW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [IDXW-1:0] desc_last,
  input logic [IDXW-1:0] prod_idx,
  input logic            ring_full,
  input logic            ring_empty,
  input logic [OVRW-1:0] ovr_cnt,
  input logic            mem_en,
  input logic            mem_we,
  input logic [3:0]      mem_be
);
  // R10: produce index only steps to its wrapped successor
  p_prod_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_idx != $past(prod_idx)) |->
      (prod_idx == (($past(prod_idx) == desc_last) ? '0 : $past(prod_idx) + 1'b1)));

  // R8: no advance while no slot is free
  p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ring_full |=> $stable(prod_idx));

  // R8: empty and full exclusive on a ring of two or more slots
  p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_last != '0) |-> !(ring_full && ring_empty));

  // R9: overrun count only increments
  p_ovr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_cnt != $past(ovr_cnt)) |-> (ovr_cnt == $past(ovr_cnt) + 1'b1));

  // R3: writes are single byte or full word, and always requested
  p_write_be_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_en && ($onehot(mem_be) || mem_be == 4'hF)));
endmodule

bind rx_desc_ring_writer rxr_checker #(.IDXW(IDXW), .OVRW(OVRW)) u_chk (
  .clk(clk), .rst_n(rst_n), .desc_last(desc_last), .prod_idx(prod_idx),
  .ring_full(ring_full), .ring_empty(ring_empty), .ovr_cnt(ovr_cnt),
  .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be)
);

// File: tb/rx_desc_ring_writer_test.sv
module rx_desc_ring_writer_test;
  localparam int PERIOD = 10;
  localparam int IDXW = 8;
  localparam int OVRW = 8;

  logic clk = 1'b0, rst_n = 1'b0, rx_en = 1'b0;
  logic [31:0] desc_base = 32'h100, stat_base = 32'h180;
  logic [IDXW-1:0] desc_last = 8'd3, cons_wdata = '0;
  logic cons_wr = 1'b0, in_valid = 1'b0, in_last = 1'b0, in_err = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, mem_en, mem_we, ring_empty, ring_full;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic [IDXW-1:0] prod_idx;
  logic [OVRW-1:0] ovr_cnt;
  logic [31:0] mem [0:1023];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  rx_desc_ring_writer #(.IDXW(IDXW), .OVRW(OVRW)) uut (.*);

  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int l = 0; l < 4; l++)
          if (mem_be[l]) mem[mem_addr[11:2]][8*l +: 8] <= mem_wdata[8*l +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[11:2]];
      end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_at(int a);
    return mem[a[11:2]][8*a[1:0] +: 8];
  endfunction

  task automatic send_frame(int n, logic [7:0] b0, bit err);
    for (int i = 0; i < n; i++) begin
      in_data  = b0 + 8'(i);
      in_last  = (i == n-1);
      in_err   = err && (i == n-1);
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
  endtask

  task automatic wait_prod(logic [IDXW-1:0] exp, string req);
    int t = 0;
    while (prod_idx !== exp && t < 100) begin @(negedge clk); t++; end
    chk(req, "produce index", 32'(prod_idx), 32'(exp));
  endtask

  task automatic write_cons(logic [IDXW-1:0] v);
    cons_wdata = v; cons_wr = 1'b1;
    @(negedge clk);
    cons_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1", "prod", 32'(prod_idx), 0);
    chk("R1", "empty", 32'(ring_empty), 1);
    chk("R1", "full", 32'(ring_full), 0);
    chk("R1", "ovr", 32'(ovr_cnt), 0);
    chk("R1", "ready", 32'(in_ready), 0);
  endtask

  task automatic t_disabled;
    int seen = 0;
    in_data = 8'h55; in_valid = 1'b1; in_last = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (in_ready) seen++;
    end
    in_valid = 1'b0; in_last = 1'b0;
    chk("R2", "ready seen while disabled", 32'(seen), 0);
    chk("R2", "prod unchanged", 32'(prod_idx), 0);
    rx_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_normal;
    send_frame(6, 8'h10, 1'b0);
    wait_prod(8'd1, "R10");
    for (int i = 0; i < 6; i++) chk("R3", "stored byte", 32'(byte_at(32'h201 + i)), 32'(8'h10 + i));
    chk("R3", "byte before buffer", 32'(byte_at(32'h200)), 32'hEE);
    chk("R3", "byte after frame", 32'(byte_at(32'h207)), 32'hEE);
    chk("R5", "status word0 (bit31 of ctl ignored, R4)", mem[32'h180 >> 2], 32'h0000_0005);
    chk("R5", "status word1", mem[32'h184 >> 2], 32'h0);
    chk("R8", "not empty", 32'(ring_empty), 0);
  endtask

  task automatic t_error;
    send_frame(3, 8'h40, 1'b1);
    wait_prod(8'd2, "R10");
    chk("R6", "status error bit", mem[32'h188 >> 2], 32'h1000_0002);
    chk("R6", "last byte", 32'(byte_at(32'h283)), 32'h42);
  endtask

  task automatic t_trunc;
    send_frame(7, 8'h70, 1'b0);
    wait_prod(8'd3, "R10");
    for (int i = 0; i < 4; i++) chk("R7", "kept byte", 32'(byte_at(32'h300 + i)), 32'(8'h70 + i));
    chk("R7", "byte past buffer", 32'(byte_at(32'h304)), 32'hEE);
    chk("R7", "status trunc", mem[32'h190 >> 2], 32'h0080_0003);
    chk("R8", "full", 32'(ring_full), 1);
  endtask

  task automatic t_drop;
    send_frame(5, 8'hA0, 1'b0);
    repeat (6) @(negedge clk);
    chk("R9", "overrun count", 32'(ovr_cnt), 1);
    chk("R9", "prod held", 32'(prod_idx), 3);
    chk("R9", "slot3 buffer untouched", 32'(byte_at(32'h380)), 32'hEE);
    chk("R9", "slot3 status untouched", mem[32'h198 >> 2], 32'hFFFF_FFFF);
  endtask

  task automatic t_wrap;
    write_cons(8'd2);
    chk("R8", "not full after consume", 32'(ring_full), 0);
    send_frame(2, 8'hC0, 1'b0);
    wait_prod(8'd0, "R10");
    chk("R10", "slot3 byte", 32'(byte_at(32'h381)), 32'hC1);
    chk("R4", "slot3 status (junk ctl bits)", mem[32'h198 >> 2], 32'h0000_0001);
    write_cons(8'd0);
    chk("R8", "empty when consume catches up", 32'(ring_empty), 1);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'hEEEE_EEEE;
    for (int i = 0; i < 8; i++) mem[(32'h180 >> 2) + i] = 32'hFFFF_FFFF;
    mem[32'h100 >> 2] = 32'h201; mem[32'h104 >> 2] = 32'h8000_003F;
    mem[32'h108 >> 2] = 32'h281; mem[32'h10C >> 2] = 32'h0000_003F;
    mem[32'h110 >> 2] = 32'h300; mem[32'h114 >> 2] = 32'h0000_0003;
    mem[32'h118 >> 2] = 32'h380; mem[32'h11C >> 2] = 32'h7FFF_F83F;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_disabled;
    t_normal;
    t_error;
    t_trunc;
    t_drop;
    t_wrap;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule